// File: doc/BRIEF.md
# Output Driver Fault Supervisor

This block supervises a bank of output stages, each of which can sit off (high impedance), drive its high-side switch, or drive its low-side switch. Each cycle it takes the drive pattern the host requests and synchronized fault indications from the analog sensing: a supply undervoltage line, and per-stage lines for open load (undercurrent), overcurrent, thermal prewarning and thermal shutdown. From these it produces the drive pattern the stages actually see, a per-stage on/off status word, and four status flags: supply fail, open load, short circuit and thermal prewarning.

Each fault class follows its own rule. Undervoltage, open load and overcurrent must persist longer than a programmable cycle count before they are recognised. A condition that drops out before then restarts its counter. Some flags are sticky until the host sends a one-cycle status-reset pulse, while the prewarning flag simply tracks its comparators. An undervoltage disables the outputs only while it lasts. A thermal shutdown keeps them off until the stages have cooled and a reset pulse arrives. An overcurrent removes only the affected stage, and only when overcurrent shutdown is enabled. An inhibit input clears everything and forces the outputs off. Releasing it starts an internal power-on hold.

Top module: `drvFaultSup`

## Requirements
- R1: Each stage's drive is a 2-bit code in its slice `[2i+1:2i]`: 00 off, 01 high-side on, 10 low-side on. A requested code of 11 yields 00, and 11 never appears at `driveOut`. `statusOut[i]` is 1 exactly when stage i's drive is not 00.
- R2: When `uvIn` is sampled high on `uvDelay`+1 consecutive edges, `psfFlag` rises at that last edge and all drives become 00 at that same edge. Before that edge, outputs and flag are unchanged.
- R3: At the first edge that samples `uvIn` low, the drives follow the request again, and `psfFlag` stays 1.
- R4: `psfFlag`, `oplFlag` and `scdFlag` clear only at an edge that samples `srrPulse` high. If the flag's fault is still recognised at that edge, the flag stays 1.
- R5: If a delayed fault condition drops for one edge before its count completes, counting restarts from zero, so no flag is set.
- R6: When an on stage has `openLoadIn[i]` sampled high on `olDelay`+1 consecutive edges, `oplFlag` is set. Drives are not changed. An off stage never sets the flag.
- R7: `tpFlag` equals the OR of `thermWarnIn` sampled at the previous edge, with no latching, and drives are unaffected.
- R8: An edge that samples any `thermShutIn` bit high sets all drives and `statusOut` to 0. They stay 0 until an edge that samples `srrPulse` high while all `thermShutIn` bits are low.
- R9: With `ocsEn` high, when an on stage has `overCurIn[i]` sampled high on `scDelay`+1 consecutive edges, that stage goes to 00 and `scdFlag` is set at that edge. The other stages are unchanged.
- R10: With `ocsEn` low, a qualified overcurrent sets `scdFlag` but leaves all drives unchanged.
- R11: A status-reset pulse clears `scdFlag` and restores, at that same edge, every stage that overcurrent had switched off.
- R12: While `inhibit` is high, all drives are 00 and all four flags are 0.
- R13: After `inhibit` falls, drives stay 00 for `POR_CYCLES` (default 3) further edges and follow the request at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inhibit | input | 1 | Inhibit: forces outputs off and clears status |
| srrPulse | input | 1 | One-cycle status-reset request |
| ocsEn | input | 1 | Overcurrent shutdown enable |
| reqDrive | input | 2*NUM_OUT | Requested drive code per stage |
| uvIn | input | 1 | Supply undervoltage indication |
| openLoadIn | input | NUM_OUT | Per-stage undercurrent indication |
| overCurIn | input | NUM_OUT | Per-stage overcurrent indication |
| thermWarnIn | input | NUM_OUT | Per-stage thermal prewarning comparator |
| thermShutIn | input | NUM_OUT | Per-stage thermal shutdown comparator |
| uvDelay | input | CNT_W | Undervoltage qualification delay, cycles |
| olDelay | input | CNT_W | Open-load qualification delay, cycles |
| scDelay | input | CNT_W | Overcurrent qualification delay, cycles |
| driveOut | output | 2*NUM_OUT | Effective drive code per stage |
| statusOut | output | NUM_OUT | Per-stage on status |
| psfFlag | output | 1 | Supply fail flag (sticky) |
| oplFlag | output | 1 | Open load flag (sticky) |
| scdFlag | output | 1 | Short circuit flag (sticky) |
| tpFlag | output | 1 | Thermal prewarning flag |

## Verification
The hardest case to reach is a status-reset pulse that lands while the same fault is still recognised. In that case the flag must survive rather than clear. The bench holds `uvIn` high past its delay, so the saturated counter keeps qualifying, and pulses `srrPulse` in that window. It does the same for thermal shutdown while a shutdown comparator is still high. Overcurrent shutdown removes the stage whose current qualified, and with it the condition that set the fault. The bench therefore checks, one edge apart, that only that stage dropped, and that a later reset pulse brings it back.

// File: rtl/drvFaultPkg.sv
package drvFaultPkg;

  // Per-stage drive code; DRV_BAD is never driven out
  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_LOW  = 2'b10,
    DRV_BAD  = 2'b11
  } drive_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic killAll;  // force every stage off at this edge
    logic clrCnt;   // hold all delay counters at zero
  } strobe_t;

endpackage

// File: rtl/drvFaultQual.sv
module drvFaultQual #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             qual
);

  logic [CNT_W-1:0] cnt;

  // Counts consecutive sampled cycles of cond, saturating at limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (clr || !cond)     cnt <= '0;
    else if (cnt < limit)      cnt <= cnt + 1'b1;
  end

  assign qual = cond && !clr && (cnt >= limit);

  // R5: a dropped condition restarts the count
  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    !cond |=> (cnt == '0));

endmodule

// File: rtl/drvFaultPath.sv
module drvFaultPath
  import drvFaultPkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int CNT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [NUM_OUT-1:0]     ocKill,
  input  logic [2*NUM_OUT-1:0]   reqDrive,
  input  logic                   uvIn,
  input  logic [NUM_OUT-1:0]     openLoadIn,
  input  logic [NUM_OUT-1:0]     overCurIn,
  input  logic [CNT_W-1:0]       uvDelay,
  input  logic [CNT_W-1:0]       olDelay,
  input  logic [CNT_W-1:0]       scDelay,
  output logic                   uvQual,
  output logic [NUM_OUT-1:0]     olQual,
  output logic [NUM_OUT-1:0]     ocQual,
  output logic [2*NUM_OUT-1:0]   driveOut,
  output logic [NUM_OUT-1:0]     statusOut
);

  localparam int DRV_W = 2;

  drvFaultQual #(.CNT_W(CNT_W)) uvQ (
    .clk(clk), .rstN(rstN), .clr(strb.clrCnt),
    .cond(uvIn), .limit(uvDelay), .qual(uvQual)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_stage
    drive_e driveReg;
    drive_e reqI;
    logic   isOn;

    assign reqI = drive_e'(reqDrive[DRV_W*i +: DRV_W]);
    assign isOn = (driveReg != DRV_OFF);

    // Current faults only count while the stage conducts
    drvFaultQual #(.CNT_W(CNT_W)) olQ (
      .clk(clk), .rstN(rstN), .clr(strb.clrCnt),
      .cond(openLoadIn[i] && isOn), .limit(olDelay), .qual(olQual[i])
    );

    drvFaultQual #(.CNT_W(CNT_W)) ocQ (
      .clk(clk), .rstN(rstN), .clr(strb.clrCnt),
      .cond(overCurIn[i] && isOn), .limit(scDelay), .qual(ocQual[i])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        driveReg <= DRV_OFF;
      else if (strb.killAll || ocKill[i] || reqI == DRV_BAD)
        driveReg <= DRV_OFF;
      else
        driveReg <= reqI;
    end

    assign driveOut[DRV_W*i +: DRV_W] = driveReg;
    assign statusOut[i] = isOn;

    // R1: both switches of a stage are never on together
    a_r1_no_both_sides: assert property (@(posedge clk) disable iff (!rstN)
      driveReg != DRV_BAD);

    // R9: an overcurrent kill turns this stage off
    a_r9_oc_kill_off: assert property (@(posedge clk) disable iff (!rstN)
      ocKill[i] |=> (driveReg == DRV_OFF));
  end

  // R8: a global kill leaves every stage off
  a_r8_kill_all_off: assert property (@(posedge clk) disable iff (!rstN)
    strb.killAll |=> (driveOut == '0));

endmodule

// File: rtl/drvFaultCtrl.sv
module drvFaultCtrl
  import drvFaultPkg::*;
#(
  parameter int NUM_OUT    = 4,
  parameter int POR_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inhibit,
  input  logic               srrPulse,
  input  logic               ocsEn,
  input  logic [NUM_OUT-1:0] thermWarnIn,
  input  logic [NUM_OUT-1:0] thermShutIn,
  input  logic               uvQual,
  input  logic [NUM_OUT-1:0] olQual,
  input  logic [NUM_OUT-1:0] ocQual,
  output strobe_t            strb,
  output logic [NUM_OUT-1:0] ocKill,
  output logic               psfFlag,
  output logic               oplFlag,
  output logic               scdFlag,
  output logic               tpFlag
);

  localparam int POR_W = $clog2(POR_CYCLES + 1);

  logic [POR_W-1:0]   porCnt;
  logic               porBusy;
  logic               tsdLatch, tsdNext;
  logic [NUM_OUT-1:0] ocLatch, ocLatchNext;
  logic               psfNext, oplNext, scdNext, tpNext;
  logic               anyShut;

  assign porBusy = inhibit || (porCnt != '0);
  assign anyShut = |thermShutIn;

  // Inhibit loads the power-on hold, which runs out after release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               porCnt <= '0;
    else if (inhibit)        porCnt <= POR_W'(POR_CYCLES);
    else if (porCnt != '0)   porCnt <= porCnt - 1'b1;
  end

  always_comb begin
    if (porBusy) begin
      tsdNext     = 1'b0;
      ocLatchNext = '0;
      psfNext     = 1'b0;
      oplNext     = 1'b0;
      scdNext     = 1'b0;
      tpNext      = 1'b0;
    end else begin
      // A reset request loses to a fault recognised in the same cycle
      tsdNext     = anyShut || (tsdLatch && !srrPulse);
      ocLatchNext = (ocsEn ? ocQual : '0) | (srrPulse ? '0 : ocLatch);
      psfNext     = uvQual || (psfFlag && !srrPulse);
      oplNext     = (|olQual) || (oplFlag && !srrPulse);
      scdNext     = (|ocQual) || (scdFlag && !srrPulse);
      tpNext      = |thermWarnIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsdLatch <= 1'b0;
      ocLatch  <= '0;
      psfFlag  <= 1'b0;
      oplFlag  <= 1'b0;
      scdFlag  <= 1'b0;
      tpFlag   <= 1'b0;
    end else begin
      tsdLatch <= tsdNext;
      ocLatch  <= ocLatchNext;
      psfFlag  <= psfNext;
      oplFlag  <= oplNext;
      scdFlag  <= scdNext;
      tpFlag   <= tpNext;
    end
  end

  assign strb.killAll = porBusy || uvQual || tsdNext;
  assign strb.clrCnt  = porBusy;
  assign ocKill       = ocLatchNext;

  // R4: the supply-fail flag holds without a reset request
  a_r4_psf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    psfFlag && !srrPulse && !inhibit |=> psfFlag);

  // R7: prewarning tracks the comparators of the previous cycle
  a_r7_tp_follows: assert property (@(posedge clk) disable iff (!rstN)
    !porBusy |=> (tpFlag == $past(|thermWarnIn)));

  // R8: thermal shutdown holds until a reset request
  a_r8_tsd_hold: assert property (@(posedge clk) disable iff (!rstN)
    tsdLatch && !srrPulse && !inhibit |=> tsdLatch);

  // R10: no overcurrent latch sets while shutdown is disabled
  a_r10_no_oc_latch: assert property (@(posedge clk) disable iff (!rstN)
    !ocsEn |=> ((ocLatch & ~$past(ocLatch)) == '0));

  // R12: inhibit clears every flag
  a_r12_inhibit_clears: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |=> !(psfFlag || oplFlag || scdFlag || tpFlag));

endmodule

// File: rtl/drvFaultSup.sv
module drvFaultSup
  import drvFaultPkg::*;
#(
  parameter int NUM_OUT    = 4,
  parameter int CNT_W      = 8,
  parameter int POR_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inhibit,
  input  logic                 srrPulse,
  input  logic                 ocsEn,
  input  logic [2*NUM_OUT-1:0] reqDrive,
  input  logic                 uvIn,
  input  logic [NUM_OUT-1:0]   openLoadIn,
  input  logic [NUM_OUT-1:0]   overCurIn,
  input  logic [NUM_OUT-1:0]   thermWarnIn,
  input  logic [NUM_OUT-1:0]   thermShutIn,
  input  logic [CNT_W-1:0]     uvDelay,
  input  logic [CNT_W-1:0]     olDelay,
  input  logic [CNT_W-1:0]     scDelay,
  output logic [2*NUM_OUT-1:0] driveOut,
  output logic [NUM_OUT-1:0]   statusOut,
  output logic                 psfFlag,
  output logic                 oplFlag,
  output logic                 scdFlag,
  output logic                 tpFlag
);

  strobe_t            strb;
  logic [NUM_OUT-1:0] ocKill;
  logic               uvQual;
  logic [NUM_OUT-1:0] olQual;
  logic [NUM_OUT-1:0] ocQual;

  drvFaultCtrl #(.NUM_OUT(NUM_OUT), .POR_CYCLES(POR_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .inhibit(inhibit), .srrPulse(srrPulse),
    .ocsEn(ocsEn), .thermWarnIn(thermWarnIn), .thermShutIn(thermShutIn),
    .uvQual(uvQual), .olQual(olQual), .ocQual(ocQual),
    .strb(strb), .ocKill(ocKill),
    .psfFlag(psfFlag), .oplFlag(oplFlag), .scdFlag(scdFlag), .tpFlag(tpFlag)
  );

  drvFaultPath #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) path (
    .clk(clk), .rstN(rstN), .strb(strb), .ocKill(ocKill),
    .reqDrive(reqDrive), .uvIn(uvIn), .openLoadIn(openLoadIn),
    .overCurIn(overCurIn), .uvDelay(uvDelay), .olDelay(olDelay),
    .scDelay(scDelay), .uvQual(uvQual), .olQual(olQual), .ocQual(ocQual),
    .driveOut(driveOut), .statusOut(statusOut)
  );

endmodule

// File: tb/drvFaultSup_test.sv
`timescale 1ns/1ps
module drvFaultSup_test;

  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int POR = 3;
  localparam int UVD = 3;
  localparam int OLD = 2;
  localparam int SCD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inhibit = 1'b0, srrPulse = 1'b0, ocsEn = 1'b0, uvIn = 1'b0;
  logic [2*N-1:0] reqDrive = '0;
  logic [N-1:0] openLoadIn = '0, overCurIn = '0, thermWarnIn = '0, thermShutIn = '0;
  logic [CW-1:0] uvDelay = CW'(UVD), olDelay = CW'(OLD), scDelay = CW'(SCD);
  logic [2*N-1:0] driveOut;
  logic [N-1:0] statusOut;
  logic psfFlag, oplFlag, scdFlag, tpFlag;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // stage0 high, stage1 off, stage2 low, stage3 high
  localparam logic [2*N-1:0] PAT = 8'b01_10_00_01;

  always #10 clk = ~clk;

  drvFaultSup #(.NUM_OUT(N), .CNT_W(CW), .POR_CYCLES(POR)) uut (
    .clk(clk), .rstN(rstN), .inhibit(inhibit), .srrPulse(srrPulse),
    .ocsEn(ocsEn), .reqDrive(reqDrive), .uvIn(uvIn), .openLoadIn(openLoadIn),
    .overCurIn(overCurIn), .thermWarnIn(thermWarnIn), .thermShutIn(thermShutIn),
    .uvDelay(uvDelay), .olDelay(olDelay), .scDelay(scDelay),
    .driveOut(driveOut), .statusOut(statusOut), .psfFlag(psfFlag),
    .oplFlag(oplFlag), .scdFlag(scdFlag), .tpFlag(tpFlag)
  );

  function automatic logic [2*N-1:0] expDrive(input logic [2*N-1:0] r);
    logic [2*N-1:0] e;
    for (int i = 0; i < N; i++)
      e[2*i +: 2] = (r[2*i +: 2] == 2'b11) ? 2'b00 : r[2*i +: 2];
    return e;
  endfunction

  function automatic logic [N-1:0] expStatus(input logic [2*N-1:0] d);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = (d[2*i +: 2] != 2'b00);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic srr();
    srrPulse = 1'b1;
    step(1);
    srrPulse = 1'b0;
  endtask

  task automatic tReset();
    chk("R12 reset drive", 32'(driveOut), 0);
    chk("R12 reset flags", {psfFlag, oplFlag, scdFlag, tpFlag}, 0);
    rstN = 1'b1;
    reqDrive = PAT;
    step(1);
    chk("R1 pattern", 32'(driveOut), 32'(expDrive(PAT)));
    chk("R1 status", 32'(statusOut), 32'(expStatus(expDrive(PAT))));
  endtask

  task automatic tEncoding();
    logic [2*N-1:0] r;
    r = PAT;
    r[3:2] = 2'b11;
    reqDrive = r;
    step(1);
    chk("R1 code 11 gives off", 32'(driveOut), 32'(expDrive(r)));
    chk("R1 status with 11", 32'(statusOut), 32'b1101);
    reqDrive = PAT;
    step(1);
  endtask

  task automatic tUnderVoltage();
    uvIn = 1'b1;
    step(UVD);
    chk("R2 before delay drive", 32'(driveOut), 32'(PAT));
    chk("R2 before delay psf", 32'(psfFlag), 0);
    step(1);
    chk("R2 recognised off", 32'(driveOut), 0);
    chk("R2 psf set", 32'(psfFlag), 1);
    srr();
    chk("R4 psf kept while uv present", 32'(psfFlag), 1);
    uvIn = 1'b0;
    step(1);
    chk("R3 immediate re-enable", 32'(driveOut), 32'(PAT));
    chk("R3 psf still set", 32'(psfFlag), 1);
    srr();
    chk("R4 psf cleared", 32'(psfFlag), 0);
  endtask

  task automatic tGlitch();
    uvIn = 1'b1;
    step(UVD);
    uvIn = 1'b0;
    step(1);
    uvIn = 1'b1;
    step(UVD);
    chk("R5 restart no psf", 32'(psfFlag), 0);
    chk("R5 restart drive on", 32'(driveOut), 32'(PAT));
    step(1);
    chk("R5 full run sets psf", 32'(psfFlag), 1);
    uvIn = 1'b0;
    step(1);
    srr();
  endtask

  task automatic tOpenLoad();
    openLoadIn = 4'b0010;  // stage1 is off
    step(OLD + 3);
    chk("R6 off stage ignored", 32'(oplFlag), 0);
    openLoadIn = 4'b0001;
    step(OLD);
    chk("R6 before delay", 32'(oplFlag), 0);
    step(1);
    chk("R6 flag set", 32'(oplFlag), 1);
    chk("R6 drive untouched", 32'(driveOut), 32'(PAT));
    openLoadIn = '0;
    step(2);
    chk("R4 opl sticky", 32'(oplFlag), 1);
    srr();
    chk("R4 opl cleared", 32'(oplFlag), 0);
  endtask

  task automatic tPrewarn();
    thermWarnIn = 4'b0100;
    step(1);
    chk("R7 tp set", 32'(tpFlag), 1);
    chk("R7 drive untouched", 32'(driveOut), 32'(PAT));
    thermWarnIn = '0;
    step(1);
    chk("R7 tp clears without request", 32'(tpFlag), 0);
  endtask

  task automatic tThermal();
    thermShutIn = 4'b0010;
    step(1);
    chk("R8 shutdown off", 32'(driveOut), 0);
    chk("R8 status low", 32'(statusOut), 0);
    srr();
    chk("R8 request while hot", 32'(driveOut), 0);
    thermShutIn = '0;
    step(2);
    chk("R8 cooled but no request", 32'(driveOut), 0);
    srr();
    chk("R8 re-enabled", 32'(driveOut), 32'(PAT));
  endtask

  task automatic tOverCurOn();
    ocsEn = 1'b1;
    overCurIn = 4'b0001;
    step(SCD);
    chk("R9 before delay", 32'(driveOut), 32'(PAT));
    step(1);
    chk("R9 only stage0 off", 32'(driveOut), 32'(PAT & 8'b11_11_11_00));
    chk("R9 scd set", 32'(scdFlag), 1);
    chk("R9 status", 32'(statusOut), 32'b1100);
    overCurIn = '0;
    step(2);
    chk("R11 stays off without request", 32'(driveOut), 32'(PAT & 8'b11_11_11_00));
    srr();
    chk("R11 scd cleared", 32'(scdFlag), 0);
    chk("R11 stage restored", 32'(driveOut), 32'(PAT));
    ocsEn = 1'b0;
  endtask

  task automatic tOverCurOff();
    ocsEn = 1'b0;
    overCurIn = 4'b0100;
    step(SCD + 1);
    chk("R10 scd set", 32'(scdFlag), 1);
    chk("R10 drive untouched", 32'(driveOut), 32'(PAT));
    overCurIn = '0;
    step(1);
    srr();
    chk("R10 scd cleared", 32'(scdFlag), 0);
  endtask

  task automatic tInhibit();
    uvIn = 1'b1;
    thermWarnIn = 4'b1000;
    step(UVD + 1);
    chk("R12 setup psf", 32'(psfFlag), 1);
    uvIn = 1'b0;
    thermWarnIn = '0;
    inhibit = 1'b1;
    step(1);
    chk("R12 inhibit off", 32'(driveOut), 0);
    chk("R12 flags cleared", {psfFlag, oplFlag, scdFlag, tpFlag}, 0);
    step(2);
    inhibit = 1'b0;
    step(POR);
    chk("R13 hold after release", 32'(driveOut), 0);
    step(1);
    chk("R13 drive resumes", 32'(driveOut), 32'(PAT));
  endtask

  initial begin
    step(3);
    tReset();
    tEncoding();
    tUnderVoltage();
    tGlitch();
    tOpenLoad();
    tPrewarn();
    tThermal();
    tOverCurOn();
    tOverCurOff();
    tInhibit();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule